// File: doc/BRIEF.md
# Bus Port Quiesce Controller

This block brings one bus port to a halted state before the logic around it is powered down. A single-cycle halt command starts the sequence. If the port already reports idle, the sequence ends at once and the halt request is never raised. Otherwise the controller raises a halt request toward the port. It then waits for the port's acknowledge, looking at it only on cycles where a millisecond tick is present. The wait ends when the acknowledge is seen or when a fixed number of ticks have gone by.

When the wait ends, the controller samples the port's idle status on its own. If the port is not idle, the halt is reported as failed. The halt request is withdrawn in every case. The port is expected to stay halted after that, until it is reset.

The done output pulses for one cycle at each completion. The failed flag holds its value until the next accepted command. All pins are plain control and status signals, and none of them carries a data stream.

Top module: `port_quiesce_ctrl`

## Requirements
- R1: After reset, halt_req_o, done_o and fail_o are all 0.
- R2: A command accepted while port_idle_i is 1 leaves halt_req_o at 0. done_o is 1 in the cycle after the command edge, and fail_o is 0 in that cycle.
- R3: A command accepted while port_idle_i is 0 sets halt_req_o to 1 in the cycle after the command edge.
- R4: While waiting, port_ack_i is looked at only in cycles where ms_tick_i is 1. An acknowledge without a tick does not end the wait.
- R5: A tick with port_ack_i at 1 during the wait ends it. In the second cycle after that tick edge, halt_req_o is 0 and done_o is 1.
- R6: If no acknowledge is seen, the wait ends on the WAIT_MS-th tick. The outputs then follow the same completion timing as R5.
- R7: At completion, fail_o becomes the inverse of port_idle_i, sampled in the cycle right after the tick that ended the wait. This holds whether the wait ended by acknowledge or by timeout.
- R8: fail_o holds its value until the next accepted command, which clears it at that command's edge.
- R9: A command that arrives while a handshake is in progress is ignored. A command that arrives in the cycle done_o is high is accepted.
- R10: done_o is high for exactly one cycle per completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_cmd_i | input | 1 | Request to quiesce the port; acted on only when no handshake is in progress |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| port_ack_i | input | 1 | Halt acknowledge from the port |
| port_idle_i | input | 1 | Idle status from the port |
| halt_req_o | output | 1 | Halt request toward the port |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Port was not idle at the end of the last handshake |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both on purpose.

The first pair is an acknowledge and the last tick of the timeout window. The bench lets WAIT_MS-1 ticks pass with no acknowledge, then raises the acknowledge on the final tick. It expects exactly one completion, with fail_o taken from idle and not from the acknowledge.

The second pair is a new command and the done pulse. The bench issues a command in the very cycle done_o is high. It expects the command to be accepted, so halt_req_o rises again on the next edge. A behavioural model is compared against all three outputs on every clock, so an extra or a missing pulse in either case shows up.

// File: rtl/quiesce_pkg.sv
package quiesce_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,
    QS_WAIT  = 2'd1,
    QS_CHECK = 2'd2
  } qs_state_e;
endpackage

// File: rtl/quiesce_tick_timer.sv
// Counts millisecond ticks during the wait and flags the last one of the window.
module quiesce_tick_timer #(
  parameter int WAIT_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic run_i,
  input  logic tick_i,
  output logic last_tick_o
);
  localparam int CNT_W = (WAIT_MS > 1) ? $clog2(WAIT_MS) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (arm_i)            cnt_q <= '0;
    else if (run_i && tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign last_tick_o = run_i && tick_i && (cnt_q == LIMIT);

  // R6: the count never leaves the timeout window
  p_cnt_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/quiesce_seq.sv
// Handshake sequencer: idle bypass, wait on tick-sampled acknowledge, check phase.
module quiesce_seq
  import quiesce_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic idle_i,
  input  logic ack_i,
  input  logic tick_i,
  input  logic last_tick_i,
  output logic busy_o,
  output logic accept_o,
  output logic arm_o,
  output logic run_o,
  output logic skip_o,
  output logic finish_o,
  output logic req_o
);
  qs_state_e state_q, state_d;
  logic      req_q;

  assign busy_o   = (state_q != QS_IDLE);
  assign accept_o = (state_q == QS_IDLE) && cmd_i;
  assign skip_o   = accept_o && idle_i;
  assign arm_o    = accept_o && !idle_i;
  assign run_o    = (state_q == QS_WAIT);
  assign finish_o = (state_q == QS_CHECK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      QS_IDLE:  if (arm_o) state_d = QS_WAIT;
      QS_WAIT:  if (tick_i && (ack_i || last_tick_i)) state_d = QS_CHECK;
      QS_CHECK: state_d = QS_IDLE;
      default:  state_d = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= QS_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (arm_o)         req_q <= 1'b1;
      else if (finish_o) req_q <= 1'b0;
    end
  end

  assign req_o = req_q;

  // R5: a tick carrying the acknowledge ends the wait
  p_ack_ends_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == QS_WAIT && tick_i && ack_i) |=> (state_q == QS_CHECK));
  // R4: without a tick the wait continues whatever the acknowledge does
  p_no_tick_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == QS_WAIT && !tick_i) |=> (state_q == QS_WAIT));
  // R3: the request is only up while a handshake runs
  p_req_in_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (state_q != QS_IDLE));
endmodule

// File: rtl/quiesce_flags.sv
// Completion pulse and sticky failure flag.
module quiesce_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic skip_i,
  input  logic finish_i,
  input  logic idle_i,
  output logic done_o,
  output logic fail_o
);
  logic done_q, fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= skip_i || finish_i;
      if (accept_i)      fail_q <= 1'b0;
      else if (finish_i) fail_q <= !idle_i;
    end
  end

  assign done_o = done_q;
  assign fail_o = fail_q;

  // R8: the failure flag only moves on a command or a completion
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i && !finish_i) |=> $stable(fail_q));
  // R7: a completion with a busy port leaves the flag set
  p_fail_on_busy_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && !idle_i) |=> (fail_q && done_q));
endmodule

// File: rtl/port_quiesce_ctrl.sv
module port_quiesce_ctrl #(
  parameter int WAIT_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_cmd_i,
  input  logic ms_tick_i,
  input  logic port_ack_i,
  input  logic port_idle_i,
  output logic halt_req_o,
  output logic done_o,
  output logic fail_o
);
  logic busy_w, accept_w, arm_w, run_w, skip_w, finish_w, last_tick_w;

  quiesce_tick_timer #(.WAIT_MS(WAIT_MS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_w),
    .run_i       (run_w),
    .tick_i      (ms_tick_i),
    .last_tick_o (last_tick_w)
  );

  quiesce_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (halt_cmd_i),
    .idle_i      (port_idle_i),
    .ack_i       (port_ack_i),
    .tick_i      (ms_tick_i),
    .last_tick_i (last_tick_w),
    .busy_o      (busy_w),
    .accept_o    (accept_w),
    .arm_o       (arm_w),
    .run_o       (run_w),
    .skip_o      (skip_w),
    .finish_o    (finish_w),
    .req_o       (halt_req_o)
  );

  quiesce_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .skip_i   (skip_w),
    .finish_i (finish_w),
    .idle_i   (port_idle_i),
    .done_o   (done_o),
    .fail_o   (fail_o)
  );

  // R2: an already idle port completes without any request
  p_skip_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cmd_i && !busy_w && port_idle_i) |=> (done_o && !halt_req_o && !fail_o));
  // R5: the request is withdrawn exactly when completion is signalled
  p_drop_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req_o) |-> done_o);
  // R9: a command during a handshake does not disturb it
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cmd_i && busy_w && !finish_w) |=> (busy_w && !done_o));
  // R10: a completion pulse is not repeated without a new command
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !halt_cmd_i) |=> !done_o);
endmodule

// File: tb/port_quiesce_ctrl_bench.sv
`timescale 1ns/1ps
module port_quiesce_ctrl_bench;
  localparam int WAIT_MS = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_cmd = 1'b0, ms_tick = 1'b0, port_ack = 1'b0, port_idle = 1'b0;
  logic halt_req, done, fail;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  port_quiesce_ctrl #(.WAIT_MS(WAIT_MS)) u_port_quiesce_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_cmd_i(halt_cmd), .ms_tick_i(ms_tick),
    .port_ack_i(port_ack), .port_idle_i(port_idle),
    .halt_req_o(halt_req), .done_o(done), .fail_o(fail)
  );

  // Behavioural reference: phase 0 = free, 1 = waiting, 2 = checking
  int   m_phase = 0;
  int   m_ticks = 0;
  logic m_req = 1'b0, m_done = 1'b0, m_fail = 1'b0;

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_ticks = 0; m_req = 0; m_done = 0; m_fail = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (halt_cmd) begin
          m_fail = 0;
          if (port_idle) m_done = 1;
          else begin m_phase = 1; m_ticks = 0; m_req = 1; end
        end
      end else if (m_phase == 1) begin
        if (ms_tick) begin
          m_ticks++;
          if (port_ack || m_ticks == WAIT_MS) m_phase = 2;
        end
      end else begin
        m_fail = !port_idle;
        m_done = 1;
        m_req  = 0;
        m_phase = 0;
      end
    end
    #1;
    check("R3 model halt_req", halt_req, m_req);
    check("R10 model done", done, m_done);
    check("R7 model fail", fail, m_fail);
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cmd();
    halt_cmd = 1'b1; step(1); halt_cmd = 1'b0;
  endtask

  task automatic give_ticks(int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; step(1); ms_tick = 1'b0; step(2);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 reset halt_req", halt_req, 1'b0);
    check("R1 reset done", done, 1'b0);
    check("R1 reset fail", fail, 1'b0);

    // Idle bypass
    port_idle = 1'b1;
    pulse_cmd();
    check("R2 bypass done", done, 1'b1);
    check("R2 bypass no request", halt_req, 1'b0);
    check("R2 bypass fail clear", fail, 1'b0);
    step(1);
    check("R10 done single cycle", done, 1'b0);

    // Handshake with acknowledge, ack held without tick first
    port_idle = 1'b0;
    pulse_cmd();
    check("R3 request raised", halt_req, 1'b1);
    port_ack = 1'b1;
    step(5);
    check("R4 ack without tick ignored", halt_req, 1'b1);
    check("R4 no completion", done, 1'b0);
    halt_cmd = 1'b1; step(2); halt_cmd = 1'b0;
    check("R9 busy command ignored", halt_req, 1'b1);
    port_idle = 1'b1;
    ms_tick = 1'b1; step(1); ms_tick = 1'b0; port_ack = 1'b0;
    check("R5 still in check cycle", done, 1'b0);
    step(1);
    check("R5 done after ack", done, 1'b1);
    check("R5 request dropped", halt_req, 1'b0);
    check("R7 idle port not failed", fail, 1'b0);
    step(1);
    check("R10 one pulse", done, 1'b0);

    // Timeout with busy port
    port_idle = 1'b0;
    pulse_cmd();
    give_ticks(WAIT_MS - 1);
    check("R6 request up before last tick", halt_req, 1'b1);
    ms_tick = 1'b1; step(1); ms_tick = 1'b0; step(1);
    check("R6 done on timeout", done, 1'b1);
    check("R6 request dropped on timeout", halt_req, 1'b0);
    check("R7 fail on busy port", fail, 1'b1);
    step(10);
    check("R8 fail held", fail, 1'b1);

    // New command clears fail; command in done cycle is accepted
    pulse_cmd();
    check("R8 fail cleared by command", fail, 1'b0);
    port_idle = 1'b1; port_ack = 1'b1;
    ms_tick = 1'b1; step(1); ms_tick = 1'b0; port_ack = 1'b0; step(1);
    check("R5 done second handshake", done, 1'b1);
    port_idle = 1'b0;
    pulse_cmd();
    check("R9 command in done cycle accepted", halt_req, 1'b1);

    // Acknowledge on the final tick of the window, port still busy
    give_ticks(WAIT_MS - 1);
    port_ack = 1'b1; ms_tick = 1'b1; step(1); ms_tick = 1'b0; port_ack = 1'b0; step(1);
    check("R6 completion at window edge", done, 1'b1);
    check("R7 idle decides fail", fail, 1'b1);
    step(1);
    check("R10 no second pulse", done, 1'b0);
    step(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule